// File: doc/BRIEF.md
# Message Object Scan and Arbitration

This block owns the per-object status flags of a bank of message objects in a CAN controller and decides, every cycle, which object a frame touches. For reception it walks the objects from index 0 upward and names the object that will store the next accepted frame. For transmission it names the pending object with the lowest index. Each object is set up from outside as valid or invalid, as receive or transmit, and with or without an end-of-buffer marker. Acceptance filtering happens elsewhere and arrives as one match bit per object.

Receive objects that follow each other form a FIFO group, and the last member carries the end-of-buffer marker. A frame goes into the lowest free member of the group. When the whole group is full, the frame overwrites the marked object and its lost-message flag is raised. An object that is alone and carries the marker therefore behaves as a single overwrite buffer. A store pulse or a transmit-done pulse updates the flags of the selected object on the next clock edge. Software clear vectors take flags back down. Two packed 16-bit summaries give quick polling: the new-data bits of the low objects and the interrupt-pending bits of the high objects.

Top module: `msg_obj_arbiter`

## Requirements
- R1: After reset, every new-data, interrupt-pending, lost-message and transmit-request flag is 0, both summaries are 0, and with all configuration inputs at 0 both `rx_hit` and `tx_pend` are 0.
- R2: A receive candidate is an object with `obj_valid`=1, `obj_is_tx`=0 and `rx_match`=1. `rx_sel` is the lowest candidate whose new-data is clear, unless a lower candidate with new-data set and `obj_eob`=1 comes first. Invalid, transmit-direction and non-matching objects are skipped. `rx_sel` and `rx_hit` follow the inputs in the same cycle.
- R3: One cycle after `rx_store`=1 with `rx_hit`=1, the new-data and interrupt-pending flags of `rx_sel` are 1.
- R4: When every candidate up to and including the end-of-buffer object holds new data, `rx_sel` is that end-of-buffer object and `rx_overwrite`=1. A store then sets its lost-message flag one cycle later and leaves its new-data flag at 1.
- R5: A full end-of-buffer object stops the scan. A free candidate at a higher index is not selected.
- R6: `rx_store` with `rx_hit`=0 changes no flag.
- R7: `tx_sel` is the lowest index with transmit-request=1, `obj_valid`=1 and `obj_is_tx`=1, and `tx_pend` tells whether one exists. Both follow in the same cycle.
- R8: One cycle after `tx_done`=1 with `tx_pend`=1, the transmit-request of `tx_sel` is 0 and its interrupt-pending is 1. `tx_done` with `tx_pend`=0 changes no flag.
- R9: `newdat_lo[k]` is the new-data flag of object k. `intpnd_hi[k]` is the interrupt-pending flag of object 16+k, for k = 0..15.
- R10: A 1 in `clr_newdat`, `clr_intpnd` or `clr_msglost` clears that flag of that object one cycle later. A hardware set of the same flag in the same cycle wins over the clear.
- R11: A 1 in `tx_req_set` sets that object's transmit-request flag one cycle later, whatever the object's configuration. Selection still masks the flag with valid and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| obj_valid | input | 32 | Object is in use |
| obj_is_tx | input | 32 | Object direction: 1 = transmit, 0 = receive |
| obj_eob | input | 32 | Object closes a receive FIFO group |
| rx_match | input | 32 | Object accepts the incoming frame's identifier |
| rx_store | input | 1 | Incoming frame is stored into `rx_sel` this cycle |
| tx_req_set | input | 32 | Per-object transmit-request set pulses |
| tx_done | input | 1 | Transmission of `tx_sel` finished successfully |
| clr_newdat | input | 32 | Per-object new-data clear |
| clr_intpnd | input | 32 | Per-object interrupt-pending clear |
| clr_msglost | input | 32 | Per-object lost-message clear |
| rx_hit | output | 1 | A receive target exists |
| rx_sel | output | 5 | Index of the receive target |
| rx_overwrite | output | 1 | The receive target still holds unread data |
| tx_pend | output | 1 | An eligible transmit request exists |
| tx_sel | output | 5 | Index of the next object to transmit |
| newdat | output | 32 | New-data flags |
| intpnd | output | 32 | Interrupt-pending flags |
| msglost | output | 32 | Lost-message flags |
| txrqst | output | 32 | Transmit-request flags |
| newdat_lo | output | 16 | New-data summary of objects 0..15 |
| intpnd_hi | output | 16 | Interrupt-pending summary of objects 16..31 |

## Verification
The selections `rx_hit`, `rx_sel`, `rx_overwrite`, `tx_pend` and `tx_sel` are combinational, so they are due in the same cycle as the configuration and flags they depend on. Every flag and both summaries change exactly one clock edge after a store, transmit-done, set or clear pulse. The bench changes inputs on the falling edge and reads selections 2 ns later in that same low phase. A pulse is held for one full cycle and dropped at the next falling edge, and the flags are read just after that edge, which is the first sample point after the single register stage.

// File: rtl/msgobj_pkg.sv
package msgobj_pkg;

  localparam int unsigned OBJ_COUNT = 32;
  localparam int unsigned SUMMARY_W = 16;

  typedef struct packed {
    logic newdat;
    logic intpnd;
    logic msglost;
    logic txrqst;
  } obj_flags_t;

endpackage

// File: rtl/mo_lowest_pick.sv
module mo_lowest_pick #(
  parameter int unsigned N = 32,
  parameter int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output logic [W-1:0] idx,
  output logic [N-1:0] grant
);

  // Isolate the lowest set bit, then encode it.
  always_comb begin
    grant = req & (~req + N'(1));
    hit   = |req;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = W'(i);
    end
  end

endmodule

// File: rtl/mo_rx_pick.sv
module mo_rx_pick #(
  parameter int unsigned N = 32,
  parameter int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] obj_valid,
  input  logic [N-1:0] obj_is_tx,
  input  logic [N-1:0] obj_eob,
  input  logic [N-1:0] rx_match,
  input  logic [N-1:0] newdat,
  output logic         hit,
  output logic [W-1:0] sel,
  output logic [N-1:0] grant,
  output logic         overwrite
);

  logic [N-1:0] cand;
  logic [N-1:0] stop;

  // A candidate ends the scan when it is free or when it closes a full group.
  always_comb begin
    cand = obj_valid & ~obj_is_tx & rx_match;
    stop = cand & (~newdat | obj_eob);
  end

  mo_lowest_pick #(.N(N), .W(W)) u_pick (
    .req   (stop),
    .hit   (hit),
    .idx   (sel),
    .grant (grant)
  );

  assign overwrite = |(grant & newdat);

endmodule

// File: rtl/mo_flag_bank.sv
module mo_flag_bank
  import msgobj_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] store_grant,
  input  logic [N-1:0] txdone_grant,
  input  logic [N-1:0] set_tx,
  input  logic [N-1:0] clr_nd,
  input  logic [N-1:0] clr_ip,
  input  logic [N-1:0] clr_ml,
  output logic [N-1:0] newdat,
  output logic [N-1:0] intpnd,
  output logic [N-1:0] msglost,
  output logic [N-1:0] txrqst
);

  for (genvar g = 0; g < N; g++) begin : g_obj
    obj_flags_t flg_q;
    obj_flags_t flg_d;
    logic       flg_en;

    // Next state: hardware sets take priority over software clears.
    always_comb begin
      flg_en         = store_grant[g] | txdone_grant[g] | set_tx[g]
                     | clr_nd[g] | clr_ip[g] | clr_ml[g];
      flg_d.newdat   = (flg_q.newdat & ~clr_nd[g]) | store_grant[g];
      flg_d.intpnd   = (flg_q.intpnd & ~clr_ip[g]) | store_grant[g]
                     | txdone_grant[g];
      flg_d.msglost  = (flg_q.msglost & ~clr_ml[g])
                     | (store_grant[g] & flg_q.newdat);
      flg_d.txrqst   = (flg_q.txrqst & ~txdone_grant[g]) | set_tx[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg_q <= '0;
      end else if (flg_en) begin
        flg_q <= flg_d;
      end
    end

    assign newdat[g]  = flg_q.newdat;
    assign intpnd[g]  = flg_q.intpnd;
    assign msglost[g] = flg_q.msglost;
    assign txrqst[g]  = flg_q.txrqst;

    assert_store_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      store_grant[g] |=> (flg_q.newdat && flg_q.intpnd));

    assert_lost_on_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (store_grant[g] && flg_q.newdat) |=> (flg_q.msglost && flg_q.newdat));

    assert_txdone_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (txdone_grant[g] && !set_tx[g]) |=> (flg_q.intpnd && !flg_q.txrqst));

    assert_txreq_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_tx[g] |=> flg_q.txrqst);
  end

endmodule

// File: rtl/msg_obj_arbiter.sv
module msg_obj_arbiter
  import msgobj_pkg::*;
#(
  parameter int unsigned N_OBJ = OBJ_COUNT,
  parameter int unsigned SUM_W = SUMMARY_W,
  parameter int unsigned IDX_W = (N_OBJ > 1) ? $clog2(N_OBJ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OBJ-1:0] obj_valid,
  input  logic [N_OBJ-1:0] obj_is_tx,
  input  logic [N_OBJ-1:0] obj_eob,
  input  logic [N_OBJ-1:0] rx_match,
  input  logic             rx_store,
  input  logic [N_OBJ-1:0] tx_req_set,
  input  logic             tx_done,
  input  logic [N_OBJ-1:0] clr_newdat,
  input  logic [N_OBJ-1:0] clr_intpnd,
  input  logic [N_OBJ-1:0] clr_msglost,
  output logic             rx_hit,
  output logic [IDX_W-1:0] rx_sel,
  output logic             rx_overwrite,
  output logic             tx_pend,
  output logic [IDX_W-1:0] tx_sel,
  output logic [N_OBJ-1:0] newdat,
  output logic [N_OBJ-1:0] intpnd,
  output logic [N_OBJ-1:0] msglost,
  output logic [N_OBJ-1:0] txrqst,
  output logic [SUM_W-1:0] newdat_lo,
  output logic [SUM_W-1:0] intpnd_hi
);

  localparam int unsigned HI_BASE = N_OBJ - SUM_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = rst_sync_q[1];

  // Receive target selection.
  logic [N_OBJ-1:0] rx_grant;

  mo_rx_pick #(.N(N_OBJ), .W(IDX_W)) u_rx_pick (
    .obj_valid (obj_valid),
    .obj_is_tx (obj_is_tx),
    .obj_eob   (obj_eob),
    .rx_match  (rx_match),
    .newdat    (newdat),
    .hit       (rx_hit),
    .sel       (rx_sel),
    .grant     (rx_grant),
    .overwrite (rx_overwrite)
  );

  // Transmit selection: lowest eligible request.
  logic [N_OBJ-1:0] tx_req_vec;
  logic [N_OBJ-1:0] tx_grant;

  assign tx_req_vec = txrqst & obj_valid & obj_is_tx;

  mo_lowest_pick #(.N(N_OBJ), .W(IDX_W)) u_tx_pick (
    .req   (tx_req_vec),
    .hit   (tx_pend),
    .idx   (tx_sel),
    .grant (tx_grant)
  );

  // Gate the one-hot grants with their event pulses.
  logic [N_OBJ-1:0] store_grant;
  logic [N_OBJ-1:0] txdone_grant;

  assign store_grant  = rx_grant & {N_OBJ{rx_store}};
  assign txdone_grant = tx_grant & {N_OBJ{tx_done}};

  mo_flag_bank #(.N(N_OBJ)) u_flags (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .store_grant  (store_grant),
    .txdone_grant (txdone_grant),
    .set_tx       (tx_req_set),
    .clr_nd       (clr_newdat),
    .clr_ip       (clr_intpnd),
    .clr_ml       (clr_msglost),
    .newdat       (newdat),
    .intpnd       (intpnd),
    .msglost      (msglost),
    .txrqst       (txrqst)
  );

  // Packed summaries.
  assign newdat_lo = newdat[SUM_W-1:0];
  assign intpnd_hi = intpnd[HI_BASE +: SUM_W];

  assert_rx_target_ok_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    rx_hit |-> (obj_valid[rx_sel] && !obj_is_tx[rx_sel] && rx_match[rx_sel]));

  assert_tx_target_ok_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    tx_pend |-> (txrqst[tx_sel] && obj_valid[tx_sel] && obj_is_tx[tx_sel]));

  assert_tx_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(tx_grant));

  assert_miss_ignored_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rx_store && !rx_hit && clr_newdat == '0) |=> $stable(newdat));

endmodule

// File: tb/msg_obj_arbiter_test.sv
module msg_obj_arbiter_test;

  localparam int N = 32;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  obj_valid, obj_is_tx, obj_eob, rx_match;
  logic          rx_store, tx_done;
  logic [N-1:0]  tx_req_set, clr_newdat, clr_intpnd, clr_msglost;
  logic          rx_hit, rx_overwrite, tx_pend;
  logic [4:0]    rx_sel, tx_sel;
  logic [N-1:0]  newdat, intpnd, msglost, txrqst;
  logic [15:0]   newdat_lo, intpnd_hi;

  int n_checks = 0;
  int n_fail   = 0;

  msg_obj_arbiter uut (
    .clk(clk), .rst_n(rst_n),
    .obj_valid(obj_valid), .obj_is_tx(obj_is_tx), .obj_eob(obj_eob),
    .rx_match(rx_match), .rx_store(rx_store), .tx_req_set(tx_req_set),
    .tx_done(tx_done), .clr_newdat(clr_newdat), .clr_intpnd(clr_intpnd),
    .clr_msglost(clr_msglost), .rx_hit(rx_hit), .rx_sel(rx_sel),
    .rx_overwrite(rx_overwrite), .tx_pend(tx_pend), .tx_sel(tx_sel),
    .newdat(newdat), .intpnd(intpnd), .msglost(msglost), .txrqst(txrqst),
    .newdat_lo(newdat_lo), .intpnd_hi(intpnd_hi)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drop all pulses at the falling edge after one full cycle, then settle.
  task automatic end_pulse();
    @(negedge clk);
    rx_store = 1'b0; tx_done = 1'b0; tx_req_set = '0;
    clr_newdat = '0; clr_intpnd = '0; clr_msglost = '0;
    #2;
  endtask

  task automatic store_once();
    @(negedge clk);
    rx_store = 1'b1;
    end_pulse();
  endtask

  task automatic done_once();
    @(negedge clk);
    tx_done = 1'b1;
    end_pulse();
  endtask

  task automatic t_reset();
    check("R1 newdat", newdat, '0);
    check("R1 intpnd", intpnd, '0);
    check("R1 msglost", msglost, '0);
    check("R1 txrqst", txrqst, '0);
    check("R1 summaries", {newdat_lo, intpnd_hi}, '0);
    check("R1 hit/pend", {rx_hit, tx_pend}, 2'b00);
  endtask

  task automatic t_fifo_fill();
    @(negedge clk);
    obj_valid = (32'hF) | (32'h1 << 5) | (32'hF << 16);
    obj_is_tx = 32'h1F << 16;
    obj_eob   = (32'h1 << 3) | (32'h1 << 5);
    rx_match  = '1;
    #2;
    for (int k = 0; k < 4; k++) begin
      check("R2 fifo order", {rx_hit, rx_overwrite, rx_sel}, {2'b10, 5'(k)});
      store_once();
      check("R3 newdat set", newdat[k], 1'b1);
      check("R3 intpnd set", intpnd[k], 1'b1);
    end
    check("R9 newdat_lo", newdat_lo, 16'h000F);
    check("R4 full group picks eob", {rx_hit, rx_overwrite, rx_sel}, {2'b11, 5'd3});
    check("R5 eob stops scan", rx_sel, 5'd3);
    store_once();
    check("R4 msglost on eob", msglost, 32'h8);
    check("R4 newdat kept", newdat, 32'hF);
  endtask

  task automatic t_skip_and_miss();
    @(negedge clk);
    rx_match = (32'h1 << 4) | (32'h1 << 5);
    #2;
    check("R2 invalid skipped", {rx_hit, rx_sel}, {1'b1, 5'd5});
    @(negedge clk);
    rx_match = (32'h1 << 4) | (32'h1 << 16);
    #2;
    check("R2 tx-dir skipped", rx_hit, 1'b0);
    store_once();
    check("R6 miss newdat", newdat, 32'hF);
    check("R6 miss intpnd", intpnd, 32'hF);
    check("R6 miss msglost", msglost, 32'h8);
    @(negedge clk);
    rx_match = '1;
    #2;
  endtask

  task automatic t_clear();
    @(negedge clk);
    clr_newdat = 32'h2;
    end_pulse();
    check("R10 clear newdat", newdat, 32'hD);
    check("R2 refill hole", rx_sel, 5'd1);
    store_once();
    check("R3 refill", newdat, 32'hF);
    @(negedge clk);
    rx_store = 1'b1; clr_msglost = 32'h8;
    end_pulse();
    check("R10 set beats clear msglost", msglost[3], 1'b1);
    @(negedge clk);
    clr_msglost = 32'h8; clr_intpnd = 32'hF;
    end_pulse();
    check("R10 clear msglost", msglost, '0);
    check("R10 clear intpnd", intpnd, '0);
    @(negedge clk);
    rx_store = 1'b1; clr_newdat = 32'hF;
    end_pulse();
    check("R10 set beats clear newdat", newdat_lo, 16'h0008);
  endtask

  task automatic t_tx();
    @(negedge clk);
    tx_req_set = (32'h1 << 18) | (32'h1 << 16) | (32'h1 << 20) | (32'h1 << 2);
    end_pulse();
    check("R11 txrqst set", txrqst, (32'h1 << 18) | (32'h1 << 16) | (32'h1 << 20) | (32'h1 << 2));
    check("R7 lowest tx", {tx_pend, tx_sel}, {1'b1, 5'd16});
    done_once();
    check("R8 txrqst cleared", txrqst[16], 1'b0);
    check("R9 intpnd_hi", intpnd_hi, 16'h0001);
    check("R7 next tx", {tx_pend, tx_sel}, {1'b1, 5'd18});
    done_once();
    check("R9 intpnd_hi two", intpnd_hi, 16'h0005);
    check("R7 invalid and rx skipped", tx_pend, 1'b0);
    done_once();
    check("R8 idle done txrqst", txrqst, (32'h1 << 20) | (32'h1 << 2));
    check("R8 idle done intpnd", intpnd_hi, 16'h0005);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    obj_valid = '0; obj_is_tx = '0; obj_eob = '0; rx_match = '0;
    rx_store = 1'b0; tx_done = 1'b0; tx_req_set = '0;
    clr_newdat = '0; clr_intpnd = '0; clr_msglost = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    t_reset();
    t_fifo_fill();
    t_skip_and_miss();
    t_clear();
    t_tx();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule